// File: doc/BRIEF.md
# Bank Open-Row Shadow Tracker

This block keeps, inside a DRAM controller, a private copy of which row each DRAM bank currently holds open. The bottom 8 MiB of the memory space is carved into eight contiguous 1 MiB banks, and each bank can keep one 2 KiB row open. For every access the controller issues, the tracker tells the sequencer in advance whether the DRAM will accept the access (row hit) or refuse it while swapping rows (row miss). On a miss, it also gives the wait before the request may be sent again. The wait is longer when the row being closed was written, because that row must first be written back.

The controller has no retry-on-refusal logic. It relies on the prediction. The tracker therefore also checks each DRAM reply against what it predicted. A refusal on an access it predicted as a hit raises an unexpected-refusal flag. A reply that carries neither acceptance nor refusal raises a missing-reply flag.

A refresh pulse invalidates every bank. A bus write to the status register forces every bank to the "invalid, dirty" state. Accesses outside the tracked 8 MiB pass through with a hit prediction and change nothing.

Top module: `row_shadow_tracker`

## Requirements
- R1: During and after reset, `bank_status` reads 0x0000, and `pred_valid`, `err_unexp_nack` and `err_missing_ack` are 0.
- R2: An address below 8 MiB is tracked. Its bank is `acc_addr[22:20]` and its row is `acc_addr[19:11]`. The access is predicted a hit only when that bank is valid and its stored row equals the access row.
- R3: After a tracked access, the addressed bank is valid and stores the access row. Other banks are unchanged.
- R4: A tracked write sets the bank's dirty bit. A tracked read that hits keeps the dirty bit. A tracked read that misses clears it.
- R5: One clock after `acc_valid` is sampled, `pred_valid` is 1 for one cycle and carries `pred_hit`, `pred_tracked` and `resend_dly`. `resend_dly` is 0 on a hit, `dirty_dly` on a miss whose bank was dirty before the access, and `clean_dly` on a miss whose bank was clean.
- R6: `bank_status[7:0]` holds the valid bits and `bank_status[15:8]` holds the dirty bits. Bit i of each byte belongs to bank i.
- R7: A cycle with `stat_wr` high clears all valid bits and sets all dirty bits. This overrides any access or refresh in the same cycle. The prediction for that access still comes from the state before the cycle.
- R8: `refresh_done` clears every valid bit and leaves the dirty bits alone. If an access arrives in the same cycle, its row and dirty update still happen, but its bank stays invalid.
- R9: An access at or above 8 MiB changes no state. It is predicted as a hit with `pred_tracked` 0 and `resend_dly` 0.
- R10: `err_unexp_nack` is high in any cycle where `rsp_valid` and `rsp_nack` are both high and the latest access was predicted a hit.
- R11: `err_missing_ack` is high in any cycle where `rsp_valid` is high and both `rsp_ack` and `rsp_nack` are low.
- R12: A refusal reply to an access predicted as a miss, and an acceptance reply to any access, raise no error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access request strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 26 | Byte address of the access |
| clean_dly | input | 8 | Resend wait after a miss on a clean bank |
| dirty_dly | input | 8 | Resend wait after a miss on a dirty bank |
| refresh_done | input | 1 | Refresh completed; invalidate all banks |
| stat_wr | input | 1 | Bus write to the status register (data ignored) |
| rsp_valid | input | 1 | DRAM reply present for the latest access |
| rsp_ack | input | 1 | Reply is an acceptance |
| rsp_nack | input | 1 | Reply is a refusal |
| pred_valid | output | 1 | Prediction outputs valid |
| pred_hit | output | 1 | Access predicted to hit an open row |
| pred_tracked | output | 1 | Access fell inside the tracked 8 MiB |
| resend_dly | output | 8 | Wait before resending after a predicted miss |
| bank_status | output | 16 | Dirty bits in [15:8], valid bits in [7:0] |
| err_unexp_nack | output | 1 | Refusal arrived where a hit was predicted |
| err_missing_ack | output | 1 | Reply carried neither acceptance nor refusal |

## Verification
The properties assume that a DRAM reply always refers to the most recent access, and that at most one reply is presented per access. The bench keeps to this by driving each reply only in the cycle after its own access, and never before the next access is issued. The properties also assume the default registered prediction. Every stimulus address is built from an explicit bank, row and column, or from a known region above 8 MiB. Refresh and status writes are driven either alone or together with a single access, so the combined-cycle priorities hold exactly as stated.

// File: rtl/row_shadow_pkg.sv
`timescale 1ns/1ps
package row_shadow_pkg;

   typedef struct packed {
      logic valid;
      logic dirty;
   } slot_flags_t;

   typedef struct packed {
      logic hit;
      logic tracked;
   } pred_t;

endpackage

// File: rtl/rst_addr_decode.sv
`timescale 1ns/1ps
module rst_addr_decode #(
   parameter int ADDR_W   = 26,
   parameter int ROW_LSB  = 11,
   parameter int BANK_LSB = 20,
   parameter int BANK_W   = 3
) (
   input  logic [ADDR_W-1:0]           addr,
   output logic                        tracked,
   output logic [BANK_W-1:0]           bank,
   output logic [BANK_LSB-ROW_LSB-1:0] row
);
   localparam int TOP_LSB = BANK_LSB + BANK_W;

   assign bank    = addr[BANK_LSB +: BANK_W];
   assign row     = addr[ROW_LSB +: (BANK_LSB - ROW_LSB)];
   assign tracked = (addr[ADDR_W-1:TOP_LSB] == '0);
endmodule

// File: rtl/rst_bank_slot.sv
`timescale 1ns/1ps
module rst_bank_slot
   import row_shadow_pkg::*;
#(
   parameter int ROW_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr,
   input  logic [ROW_W-1:0] row_in,
   input  logic             refresh,
   input  logic             wipe,
   output logic             hit,
   output slot_flags_t      flags
);
   logic [ROW_W-1:0] open_row;

   assign hit = flags.valid && (open_row == row_in);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags    <= '0;
         open_row <= '0;
      end else if (wipe) begin
         flags.valid <= 1'b0;
         flags.dirty <= 1'b1;
      end else begin
         if (sel) begin
            open_row    <= row_in;
            flags.dirty <= wr | (hit & flags.dirty);
         end
         if (refresh)
            flags.valid <= 1'b0;
         else if (sel)
            flags.valid <= 1'b1;
      end
   end
endmodule

// File: rtl/rst_rsp_check.sv
`timescale 1ns/1ps
module rst_rsp_check (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic exp_hit_in,
   input  logic rsp_valid,
   input  logic rsp_ack,
   input  logic rsp_nack,
   output logic err_unexp_nack,
   output logic err_missing_ack
);
   logic exp_hit_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         exp_hit_q <= 1'b0;
      else if (load)
         exp_hit_q <= exp_hit_in;
   end

   assign err_unexp_nack  = rsp_valid & rsp_nack & exp_hit_q;
   assign err_missing_ack = rsp_valid & ~rsp_ack & ~rsp_nack;
endmodule

// File: rtl/row_shadow_tracker.sv
`timescale 1ns/1ps
module row_shadow_tracker
   import row_shadow_pkg::*;
#(
   parameter int ADDR_W    = 26,
   parameter int NUM_BANKS = 8,
   parameter int BANK_LSB  = 20,
   parameter int ROW_LSB   = 11,
   parameter int DLY_W     = 8,
   parameter bit PRED_REG  = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc_valid,
   input  logic                   acc_write,
   input  logic [ADDR_W-1:0]      acc_addr,
   input  logic [DLY_W-1:0]       clean_dly,
   input  logic [DLY_W-1:0]       dirty_dly,
   input  logic                   refresh_done,
   input  logic                   stat_wr,
   input  logic                   rsp_valid,
   input  logic                   rsp_ack,
   input  logic                   rsp_nack,
   output logic                   pred_valid,
   output logic                   pred_hit,
   output logic                   pred_tracked,
   output logic [DLY_W-1:0]       resend_dly,
   output logic [2*NUM_BANKS-1:0] bank_status,
   output logic                   err_unexp_nack,
   output logic                   err_missing_ack
);
   localparam int BANK_W = $clog2(NUM_BANKS);
   localparam int ROW_W  = BANK_LSB - ROW_LSB;

   if ((1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two");
   end
   if (ROW_W < 1) begin : g_bad_row
      $error("ROW_LSB must lie below BANK_LSB");
   end
   if (BANK_LSB + BANK_W >= ADDR_W) begin : g_bad_addr
      $error("address too narrow for the tracked region");
   end

   logic              trk;
   logic [BANK_W-1:0] bnk;
   logic [ROW_W-1:0]  rw;

   rst_addr_decode #(
      .ADDR_W(ADDR_W), .ROW_LSB(ROW_LSB), .BANK_LSB(BANK_LSB), .BANK_W(BANK_W)
   ) i_decode (
      .addr(acc_addr), .tracked(trk), .bank(bnk), .row(rw)
   );

   logic [NUM_BANKS-1:0] hit_vec, valid_vec, dirty_vec;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_slot
      slot_flags_t fl;
      rst_bank_slot #(.ROW_W(ROW_W)) i_slot (
         .clk(clk), .rst_n(rst_n),
         .sel(acc_valid && trk && (bnk == BANK_W'(i))),
         .wr(acc_write), .row_in(rw),
         .refresh(refresh_done), .wipe(stat_wr),
         .hit(hit_vec[i]), .flags(fl)
      );
      assign valid_vec[i] = fl.valid;
      assign dirty_vec[i] = fl.dirty;
   end

   assign bank_status = {dirty_vec, valid_vec};

   pred_t            pc;
   logic [DLY_W-1:0] dly_c;

   assign pc.tracked = trk;
   assign pc.hit     = trk ? hit_vec[bnk] : 1'b1;
   assign dly_c      = pc.hit ? '0 : (dirty_vec[bnk] ? dirty_dly : clean_dly);

   if (PRED_REG) begin : g_pred_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pred_valid   <= 1'b0;
            pred_hit     <= 1'b0;
            pred_tracked <= 1'b0;
            resend_dly   <= '0;
         end else begin
            pred_valid <= acc_valid;
            if (acc_valid) begin
               pred_hit     <= pc.hit;
               pred_tracked <= pc.tracked;
               resend_dly   <= dly_c;
            end
         end
      end
   end else begin : g_pred_comb
      assign pred_valid   = acc_valid;
      assign pred_hit     = pc.hit;
      assign pred_tracked = pc.tracked;
      assign resend_dly   = dly_c;
   end

   rst_rsp_check i_rsp (
      .clk(clk), .rst_n(rst_n), .load(acc_valid), .exp_hit_in(pc.hit),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_nack(rsp_nack),
      .err_unexp_nack(err_unexp_nack), .err_missing_ack(err_missing_ack)
   );
endmodule

// File: rtl/row_shadow_tracker_checker.sv
`timescale 1ns/1ps
module row_shadow_tracker_checker #(
   parameter int ADDR_W    = 26,
   parameter int NUM_BANKS = 8,
   parameter int BANK_LSB  = 20,
   parameter int DLY_W     = 8,
   parameter bit PRED_REG  = 1'b1
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   acc_valid,
   input logic                   acc_write,
   input logic [ADDR_W-1:0]      acc_addr,
   input logic                   refresh_done,
   input logic                   stat_wr,
   input logic                   rsp_valid,
   input logic                   rsp_ack,
   input logic                   rsp_nack,
   input logic                   pred_valid,
   input logic                   pred_hit,
   input logic                   pred_tracked,
   input logic [DLY_W-1:0]       resend_dly,
   input logic [2*NUM_BANKS-1:0] bank_status,
   input logic                   err_unexp_nack,
   input logic                   err_missing_ack
);
   localparam int BW = $clog2(NUM_BANKS);
   localparam int NB = NUM_BANKS;

   logic [BW-1:0] c_bank;
   logic          c_trk;
   assign c_bank = acc_addr[BANK_LSB +: BW];
   assign c_trk  = (acc_addr[ADDR_W-1:BANK_LSB+BW] == '0);

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (bank_status == '0) && !pred_valid);

   p_wipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> bank_status == {{NB{1'b1}}, {NB{1'b0}}});

   p_refresh_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_done && !stat_wr |=> bank_status[NB-1:0] == '0);

   p_refresh_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_done && !stat_wr && !acc_valid
      |=> bank_status[2*NB-1:NB] == $past(bank_status[2*NB-1:NB]));

   p_untracked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !c_trk && !stat_wr && !refresh_done |=> $stable(bank_status));

   p_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && c_trk && !stat_wr && !refresh_done |=> bank_status[$past(c_bank)]);

   p_write_dirty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && acc_write && c_trk && !stat_wr |=> bank_status[NB + $past(c_bank)]);

   if (PRED_REG) begin : g_pred_props
      p_pred_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid |=> pred_valid);

      p_hit_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && c_trk |=> !pred_hit || $past(bank_status[c_bank]));

      p_untracked_pred_r9: assert property (@(posedge clk) disable iff (!rst_n)
         acc_valid && !c_trk |=> pred_hit && !pred_tracked && (resend_dly == '0));
   end

   p_unexp_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_unexp_nack |-> rsp_valid && rsp_nack);

   p_missing_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
      err_missing_ack |-> rsp_valid && !rsp_ack && !rsp_nack);

   p_err_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_unexp_nack, err_missing_ack}));
endmodule

bind row_shadow_tracker row_shadow_tracker_checker #(
   .ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .BANK_LSB(BANK_LSB),
   .DLY_W(DLY_W), .PRED_REG(PRED_REG)
) i_checker (.*);

// File: tb/test_row_shadow_tracker.sv
`timescale 1ns/1ps
module test_row_shadow_tracker;
   localparam logic [7:0] CD = 8'd13;
   localparam logic [7:0] DD = 8'd27;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [25:0] acc_addr = '0;
   logic        refresh_done = 1'b0, stat_wr = 1'b0;
   logic        rsp_valid = 1'b0, rsp_ack = 1'b0, rsp_nack = 1'b0;
   logic        pred_valid, pred_hit, pred_tracked;
   logic [7:0]  resend_dly;
   logic [15:0] bank_status;
   logic        err_unexp_nack, err_missing_ack;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit mv[8];
   bit md[8];
   int mr[8];

   always #2.5 clk = ~clk;

   row_shadow_tracker i_row_shadow_tracker (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .clean_dly(CD), .dirty_dly(DD),
      .refresh_done(refresh_done), .stat_wr(stat_wr),
      .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_nack(rsp_nack),
      .pred_valid(pred_valid), .pred_hit(pred_hit), .pred_tracked(pred_tracked),
      .resend_dly(resend_dly), .bank_status(bank_status),
      .err_unexp_nack(err_unexp_nack), .err_missing_ack(err_missing_ack)
   );

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=%0d exp=<100000 cycles", cyc);
         summary();
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_status();
      logic [15:0] s;
      for (int i = 0; i < 8; i++) begin
         s[i]     = mv[i];
         s[8 + i] = md[i];
      end
      return s;
   endfunction

   // mode 0: reply matches prediction, 1: forced refusal, 2: no acceptance or refusal
   task automatic do_acc(input logic [25:0] a, input bit wr, input int mode,
                         input bit with_ref, input bit with_wipe);
      bit   trk, eh, e_un, e_mi;
      int   b, row;
      logic [7:0] ed;
      trk = (a < 26'h080_0000);
      b   = int'((a >> 20) & 26'd7);
      row = int'((a >> 11) & 26'h1FF);
      if (trk) begin
         eh    = mv[b] && (mr[b] == row);
         ed    = eh ? 8'd0 : (md[b] ? DD : CD);
         md[b] = wr | (eh & md[b]);
         mr[b] = row;
         mv[b] = 1'b1;
      end else begin
         eh = 1'b1;
         ed = 8'd0;
      end
      if (with_ref && !with_wipe)
         for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      if (with_wipe)
         for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; md[i] = 1'b1; end
      @(negedge clk);
      rsp_valid = 1'b0; rsp_ack = 1'b0; rsp_nack = 1'b0;
      acc_valid = 1'b1; acc_write = wr; acc_addr = a;
      refresh_done = with_ref; stat_wr = with_wipe;
      @(negedge clk);
      acc_valid = 1'b0; refresh_done = 1'b0; stat_wr = 1'b0;
      // R2 hit rule, R5 delay and timing, R9 untracked prediction
      chk(pred_valid === 1'b1 && pred_hit === eh && pred_tracked === trk && resend_dly === ed,
          trk ? (eh ? "R2 hit" : "R5 miss delay") : "R9 untracked",
          {21'd0, pred_valid, pred_hit, pred_tracked, resend_dly},
          {21'd0, 1'b1, eh, trk, ed});
      // R3/R4/R6 status layout, R7 wipe, R8 refresh
      chk(bank_status === model_status(),
          with_wipe ? "R7 wipe" : (with_ref ? "R8 refresh+acc" : (trk ? "R6 R3 R4 status" : "R9 no change")),
          {16'd0, bank_status}, {16'd0, model_status()});
      rsp_valid = 1'b1;
      rsp_ack   = (mode == 0) ? eh : 1'b0;
      rsp_nack  = (mode == 0) ? !eh : (mode == 1);
      e_un = rsp_nack && eh;
      e_mi = (mode == 2);
      #1;
      chk(err_unexp_nack === e_un && err_missing_ack === e_mi,
          (mode == 0) ? "R12 no error" : ((mode == 1) ? (eh ? "R10 unexpected nack" : "R12 expected nack") : "R11 missing ack"),
          {30'd0, err_unexp_nack, err_missing_ack}, {30'd0, e_un, e_mi});
   endtask

   task automatic do_refresh();
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      @(negedge clk);
      rsp_valid = 1'b0; refresh_done = 1'b1;
      @(negedge clk);
      refresh_done = 1'b0;
      chk(bank_status === model_status(), "R8 refresh alone", {16'd0, bank_status}, {16'd0, model_status()});
   endtask

   task automatic do_wipe();
      for (int i = 0; i < 8; i++) begin mv[i] = 1'b0; md[i] = 1'b1; end
      @(negedge clk);
      rsp_valid = 1'b0; stat_wr = 1'b1;
      @(negedge clk);
      stat_wr = 1'b0;
      chk(bank_status === model_status(), "R7 wipe alone", {16'd0, bank_status}, {16'd0, model_status()});
   endtask

   function automatic logic [25:0] mk(input int b, input int row, input int col);
      return 26'((b << 20) | (row << 11) | (col & 16'h7FF));
   endfunction

   initial begin
      int rows[5];
      logic [15:0] lfsr;
      rows = '{0, 5, 5, 511, 0};
      for (int i = 0; i < 8; i++) begin mv[i] = 0; md[i] = 0; mr[i] = 0; end
      repeat (3) @(negedge clk);
      chk(bank_status === 16'h0000 && pred_valid === 1'b0 && err_unexp_nack === 1'b0
          && err_missing_ack === 1'b0, "R1 reset", {16'd0, bank_status}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bank_status === 16'h0000 && pred_valid === 1'b0, "R1 after reset",
          {15'd0, pred_valid, bank_status}, 32'd0);

      // structured sweep over banks, rows and read/write mixes
      for (int pass = 0; pass < 4; pass++)
         for (int b = 0; b < 8; b++)
            for (int k = 0; k < 5; k++)
               do_acc(mk(b, rows[k], k * 8), ((k + pass + b) % 3) == 0, pass % 3, 1'b0, 1'b0);

      // directed corners
      do_acc(mk(3, 7, 0), 1'b0, 0, 1'b0, 1'b0);
      do_acc(mk(3, 7, 4), 1'b0, 1, 1'b0, 1'b0);   // R10 refusal on a predicted hit
      do_acc(mk(3, 9, 0), 1'b0, 1, 1'b0, 1'b0);   // R12 refusal on a predicted miss
      do_acc(26'h080_0000, 1'b1, 2, 1'b0, 1'b0);  // R9 and R11
      do_acc(26'h3F8_0010, 1'b0, 1, 1'b0, 1'b0);  // R9, refusal on untracked -> R10
      do_acc(mk(6, 1, 0), 1'b1, 0, 1'b0, 1'b0);
      do_acc(mk(6, 2, 0), 1'b0, 0, 1'b1, 1'b0);   // R8 refresh with access
      do_acc(mk(6, 2, 0), 1'b0, 0, 1'b0, 1'b0);   // miss after refresh
      do_acc(mk(2, 4, 0), 1'b1, 0, 1'b0, 1'b1);   // R7 wipe overrides access
      do_acc(mk(2, 4, 0), 1'b0, 0, 1'b0, 1'b0);   // miss on wiped bank uses dirty delay
      do_refresh();
      do_wipe();

      // pseudo-random sweep
      lfsr = 16'hACE1;
      for (int n = 0; n < 1500; n++) begin
         logic [25:0] a;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         if (lfsr[15:13] == 3'd7)
            a = 26'h080_0000 + 26'({lfsr[12:0], 5'd0});
         else
            a = mk(int'(lfsr[2:0]), (lfsr[4:3] == 2'd3) ? 511 : int'(lfsr[4:3]), int'(lfsr[11:5]));
         do_acc(a, lfsr[6], (lfsr[9:7] == 3'd0) ? 1 : ((lfsr[9:7] == 3'd1) ? 2 : 0),
                (n % 41) == 40, (n % 157) == 156);
         if ((n % 97) == 96) do_refresh();
         if ((n % 211) == 210) do_wipe();
      end

      @(negedge clk);
      rsp_valid = 1'b0;
      summary();
   end
endmodule